// File: doc/BRIEF.md
# Banked UART Host Register File

This block is the byte-wide host-side register file of one UART channel. A host reaches it through a 3-bit address and separate read and write strobes. The value held in the line control register chooses which of three banks the eight addresses map to: the general bank, the divisor bank or the enhanced bank. Shared addresses are routed so that a read and a write at the same address can land in different registers.

The block holds the control state that the rest of the UART consumes. This state covers the character format, break, the 16-bit baud divisor, FIFO control, the two flow-control characters and the interrupt enables. The line status, modem status and interrupt identification values are produced elsewhere and reach the host through this block. A receive-holding read drives a pop strobe to the receive FIFO. A transmit-holding write drives a push strobe with the byte. Some interrupt-enable and modem-control bits stay locked until an enable bit in the enhanced feature register opens them.

Top module: `uart_regbank`

## Requirements
- R1: After reset, IER, FCR, LCR, MCR, EFR and both flow-control characters read or drive 0x00, and the scratch register reads 0xFF. With the status inputs at their idle values (identification 0x01, line status 0x60), a read of address 2 returns 0x01 and a read of address 5 returns 0x60.
- R2: Bank choice follows the LCR value. LCR equal to 0xBF selects the enhanced bank, in which address 2 is EFR, address 3 is LCR, and addresses 4, 5, 6 and 7 are Xon low, Xon high, Xoff low and Xoff high. Any other value with bit 7 set selects the divisor bank. Bit 7 clear selects the general bank. EFR and the flow-control characters cannot be changed from any other bank.
- R3: In the general bank, a read of address 0 returns `rx_data` and raises `rx_pop` in that same cycle. A write to address 0 raises `thr_push` in that cycle, with `thr_data` equal to the written byte. Neither strobe is raised from any other bank.
- R4: A read of address 2 in the general or divisor bank returns the interrupt identification byte. Bits 7 and 6 of that byte both equal the stored FIFO-enable bit, bits 5:4 come from `isr_id[5:4]` only while the enhanced enable is set (0 otherwise), and bits 3:0 come from `isr_id[3:0]`.
- R5: The LCR fields drive the outputs as follows: bits 1:0 word length, bit 2 stop bits, bit 3 parity enable, bit 4 even parity, bit 5 forced parity, bit 6 break. LCR reads back at address 3 in every bank.
- R6: A write to address 2 outside the enhanced bank stores FCR bit 0 (FIFO enable), bit 3 (DMA select) and bits 7:6 (receive trigger). A 1 written in bit 1 gives a one-cycle `rx_fifo_clr` pulse, and a 1 written in bit 2 gives a one-cycle `tx_fifo_clr` pulse, each in the cycle after the write. Neither bit is kept.
- R7: EFR bit 4 is the enhanced enable. While it is 0, writes leave IER bits 7:4 and MCR bit 6 unchanged, and those bits read and drive as 0. Once the bit is 1 again, the stored values show.
- R8: In the divisor bank, address 0 holds the low byte and address 1 the high byte of `divisor`. Both bytes read back.
- R9: In the enhanced bank, addresses 0 and 1 are unmapped: reads return 0x00 and writes change nothing.
- R10: Addresses 5 and 6 outside the enhanced bank read `lsr_stat` and `msr_stat` as they stand in that cycle.
- R11: Address 7 in the general or divisor bank is a scratch byte that reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when rd_en is low |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| thr_data | output | 8 | Byte to push into the transmit FIFO |
| thr_push | output | 1 | Transmit FIFO push strobe |
| isr_id | input | 6 | Interrupt identification bits 5:0 |
| lsr_stat | input | 8 | Line status byte |
| msr_stat | input | 8 | Modem status byte |
| word_len | output | 2 | Character length code |
| stop_two | output | 1 | Longer stop period |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity |
| par_stick | output | 1 | Forced parity |
| brk | output | 1 | Break control |
| divisor | output | 16 | Baud divisor |
| fifo_en | output | 1 | FIFO enable |
| rx_fifo_clr | output | 1 | Receive FIFO clear pulse |
| tx_fifo_clr | output | 1 | Transmit FIFO clear pulse |
| dma_sel | output | 1 | DMA mode select |
| rx_trig | output | 2 | Receive trigger level code |
| xon_char | output | 16 | Xon characters {high, low} |
| xoff_char | output | 16 | Xoff characters {high, low} |
| ier_eff | output | 8 | Effective interrupt enables |
| mcr_eff | output | 8 | Effective modem control |
| efr | output | 8 | Enhanced feature register |

## Verification
The hardest case to reach from the ports is the lock on IER and MCR bits. To test it the host has to open the enhanced bank, set the enable bit, write IER and MCR from the general bank, then return to the enhanced bank to clear the enable. It then writes new values while locked and opens the lock once more, to see that the stored high bits survived. The directed sequence walks this path. Random traffic with a bias toward writing 0xBF and 0x80 to LCR then moves across all three banks, and every cycle is compared against a behavioural model.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  typedef enum logic [1:0] {
    BANK_GEN,
    BANK_DIV,
    BANK_ENH
  } bank_e;

  typedef enum logic [3:0] {
    RID_NONE,
    RID_HOLD,
    RID_IER,
    RID_ISFC,
    RID_LCR,
    RID_MCR,
    RID_LSR,
    RID_MSR,
    RID_SPR,
    RID_DLL,
    RID_DLM,
    RID_EFR,
    RID_XON_LO,
    RID_XON_HI,
    RID_XOFF_LO,
    RID_XOFF_HI
  } reg_id_e;

  // Exact key value wins over the divisor-latch bit.
  function automatic bank_e pick_bank(input logic [7:0] lcr, input logic [7:0] key);
    if (lcr == key)      return BANK_ENH;
    else if (lcr[7])     return BANK_DIV;
    else                 return BANK_GEN;
  endfunction

  function automatic reg_id_e map_reg(input bank_e b, input logic [2:0] a);
    reg_id_e r;
    r = RID_NONE;
    if (b == BANK_ENH) begin
      case (a)
        3'd2:    r = RID_EFR;
        3'd3:    r = RID_LCR;
        3'd4:    r = RID_XON_LO;
        3'd5:    r = RID_XON_HI;
        3'd6:    r = RID_XOFF_LO;
        3'd7:    r = RID_XOFF_HI;
        default: r = RID_NONE;
      endcase
    end else if (b == BANK_DIV && a == 3'd0) begin
      r = RID_DLL;
    end else if (b == BANK_DIV && a == 3'd1) begin
      r = RID_DLM;
    end else begin
      case (a)
        3'd0:    r = RID_HOLD;
        3'd1:    r = RID_IER;
        3'd2:    r = RID_ISFC;
        3'd3:    r = RID_LCR;
        3'd4:    r = RID_MCR;
        3'd5:    r = RID_LSR;
        3'd6:    r = RID_MSR;
        default: r = RID_SPR;
      endcase
    end
    return r;
  endfunction

  // Write merge: gated bits keep their old value while the gate is shut.
  function automatic logic [7:0] gate_merge(input logic [7:0] old_v, input logic [7:0] new_v,
                                            input logic [7:0] mask, input logic open);
    return open ? new_v : ((old_v & mask) | (new_v & ~mask));
  endfunction

  // Visibility: gated bits read and drive as zero while the gate is shut.
  function automatic logic [7:0] gate_hide(input logic [7:0] v, input logic [7:0] mask,
                                           input logic open);
    return open ? v : (v & ~mask);
  endfunction

endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
  import uart_regbank_pkg::*;
#(
  parameter logic [7:0] ENH_KEY = 8'hBF
) (
  input  logic [7:0] lcr,
  input  logic [2:0] addr,
  output reg_id_e    rid
);

  bank_e bank;

  always_comb begin
    bank = pick_bank(lcr, ENH_KEY);
    rid  = map_reg(bank, addr);
  end

endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_regbank_pkg::*;
#(
  parameter logic [7:0] ENH_KEY   = 8'hBF,
  parameter logic [7:0] SPR_RESET = 8'hFF,
  parameter logic [7:0] IER_GATE  = 8'hF0,
  parameter logic [7:0] MCR_GATE  = 8'h40,
  parameter logic [7:0] FCR_KEEP  = 8'hC9,
  parameter int         GATE_BIT  = 4,
  parameter int         RXCLR_BIT = 1,
  parameter int         TXCLR_BIT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  reg_id_e     rid,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  lcr_q,
  output logic [7:0]  fcr_q,
  output logic [7:0]  efr_q,
  output logic [7:0]  spr_q,
  output logic [15:0] div_q,
  output logic [15:0] xon_q,
  output logic [15:0] xoff_q,
  output logic [7:0]  ier_vis,
  output logic [7:0]  mcr_vis,
  output logic        gate_open,
  output logic        rx_clr,
  output logic        tx_clr
);

  logic [7:0] ier_q, mcr_q;

  // Named write events, one per target register.
  logic ier_we, fcr_we, lcr_we, mcr_we, spr_we, dll_we, dlm_we, efr_we;
  logic xonl_we, xonh_we, xoffl_we, xoffh_we;

  assign ier_we   = wr_en && (rid == RID_IER);
  assign fcr_we   = wr_en && (rid == RID_ISFC);
  assign lcr_we   = wr_en && (rid == RID_LCR);
  assign mcr_we   = wr_en && (rid == RID_MCR);
  assign spr_we   = wr_en && (rid == RID_SPR);
  assign dll_we   = wr_en && (rid == RID_DLL);
  assign dlm_we   = wr_en && (rid == RID_DLM);
  assign efr_we   = wr_en && (rid == RID_EFR);
  assign xonl_we  = wr_en && (rid == RID_XON_LO);
  assign xonh_we  = wr_en && (rid == RID_XON_HI);
  assign xoffl_we = wr_en && (rid == RID_XOFF_LO);
  assign xoffh_we = wr_en && (rid == RID_XOFF_HI);

  assign gate_open = efr_q[GATE_BIT];
  assign ier_vis   = gate_hide(ier_q, IER_GATE, gate_open);
  assign mcr_vis   = gate_hide(mcr_q, MCR_GATE, gate_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q  <= 8'h00;
      fcr_q  <= 8'h00;
      lcr_q  <= 8'h00;
      mcr_q  <= 8'h00;
      efr_q  <= 8'h00;
      spr_q  <= SPR_RESET;
      div_q  <= 16'h0000;
      xon_q  <= 16'h0000;
      xoff_q <= 16'h0000;
      rx_clr <= 1'b0;
      tx_clr <= 1'b0;
    end else begin
      rx_clr <= fcr_we && wdata[RXCLR_BIT];
      tx_clr <= fcr_we && wdata[TXCLR_BIT];
      if (ier_we)   ier_q        <= gate_merge(ier_q, wdata, IER_GATE, gate_open);
      if (mcr_we)   mcr_q        <= gate_merge(mcr_q, wdata, MCR_GATE, gate_open);
      if (fcr_we)   fcr_q        <= wdata & FCR_KEEP;
      if (lcr_we)   lcr_q        <= wdata;
      if (spr_we)   spr_q        <= wdata;
      if (efr_we)   efr_q        <= wdata;
      if (dll_we)   div_q[7:0]   <= wdata;
      if (dlm_we)   div_q[15:8]  <= wdata;
      if (xonl_we)  xon_q[7:0]   <= wdata;
      if (xonh_we)  xon_q[15:8]  <= wdata;
      if (xoffl_we) xoff_q[7:0]  <= wdata;
      if (xoffh_we) xoff_q[15:8] <= wdata;
    end
  end

  a_r5_lcr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !lcr_we |=> $stable(lcr_q));

  a_r2_enh_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_q != ENH_KEY) |=> ($stable(efr_q) && $stable(xon_q) && $stable(xoff_q)));

  a_r6_rxclr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |-> $past(fcr_we && wdata[RXCLR_BIT]));

  a_r6_txclr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr |-> $past(fcr_we && wdata[TXCLR_BIT]));

  a_r7_ier_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_we && !gate_open) |=> ((ier_q & IER_GATE) == $past(ier_q & IER_GATE)));

  a_r7_mcr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr_we && !gate_open) |=> ((mcr_q & MCR_GATE) == $past(mcr_q & MCR_GATE)));

endmodule

// File: rtl/uart_read_mux.sv
module uart_read_mux
  import uart_regbank_pkg::*;
#(
  parameter logic [7:0] ISR_GATE = 8'h30
) (
  input  reg_id_e     rid,
  input  logic        rd_en,
  input  logic [7:0]  rx_data,
  input  logic [5:0]  isr_id,
  input  logic [7:0]  lsr_stat,
  input  logic [7:0]  msr_stat,
  input  logic [7:0]  ier_vis,
  input  logic [7:0]  mcr_vis,
  input  logic [7:0]  lcr_q,
  input  logic [7:0]  fcr_q,
  input  logic [7:0]  efr_q,
  input  logic [7:0]  spr_q,
  input  logic [15:0] div_q,
  input  logic [15:0] xon_q,
  input  logic [15:0] xoff_q,
  input  logic        gate_open,
  output logic [7:0]  rdata
);

  logic [7:0] isr_byte;
  logic [7:0] sel;

  always_comb begin
    isr_byte = gate_hide({fcr_q[0], fcr_q[0], isr_id}, ISR_GATE, gate_open);
    case (rid)
      RID_HOLD:    sel = rx_data;
      RID_IER:     sel = ier_vis;
      RID_ISFC:    sel = isr_byte;
      RID_LCR:     sel = lcr_q;
      RID_MCR:     sel = mcr_vis;
      RID_LSR:     sel = lsr_stat;
      RID_MSR:     sel = msr_stat;
      RID_SPR:     sel = spr_q;
      RID_DLL:     sel = div_q[7:0];
      RID_DLM:     sel = div_q[15:8];
      RID_EFR:     sel = efr_q;
      RID_XON_LO:  sel = xon_q[7:0];
      RID_XON_HI:  sel = xon_q[15:8];
      RID_XOFF_LO: sel = xoff_q[7:0];
      RID_XOFF_HI: sel = xoff_q[15:8];
      default:     sel = 8'h00;
    endcase
    rdata = rd_en ? sel : 8'h00;
  end

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter logic [7:0] ENH_KEY   = 8'hBF,
  parameter logic [7:0] SPR_RESET = 8'hFF,
  parameter int         GATE_BIT  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [7:0]  rx_data,
  output logic        rx_pop,
  output logic [7:0]  thr_data,
  output logic        thr_push,
  input  logic [5:0]  isr_id,
  input  logic [7:0]  lsr_stat,
  input  logic [7:0]  msr_stat,
  output logic [1:0]  word_len,
  output logic        stop_two,
  output logic        par_en,
  output logic        par_even,
  output logic        par_stick,
  output logic        brk,
  output logic [15:0] divisor,
  output logic        fifo_en,
  output logic        rx_fifo_clr,
  output logic        tx_fifo_clr,
  output logic        dma_sel,
  output logic [1:0]  rx_trig,
  output logic [15:0] xon_char,
  output logic [15:0] xoff_char,
  output logic [7:0]  ier_eff,
  output logic [7:0]  mcr_eff,
  output logic [7:0]  efr
);

  localparam logic [7:0] IER_GATE = 8'hF0;
  localparam logic [7:0] MCR_GATE = 8'h40;
  localparam logic [7:0] ISR_GATE = 8'h30;
  localparam logic [7:0] FCR_KEEP = 8'hC9;

  reg_id_e     rid;
  logic [7:0]  lcr_q, fcr_q, efr_q, spr_q;
  logic [15:0] div_q, xon_q, xoff_q;
  logic        gate_open;

  uart_bank_decode #(.ENH_KEY(ENH_KEY)) u_dec (
    .lcr  (lcr_q),
    .addr (addr),
    .rid  (rid)
  );

  uart_ctrl_regs #(
    .ENH_KEY   (ENH_KEY),
    .SPR_RESET (SPR_RESET),
    .IER_GATE  (IER_GATE),
    .MCR_GATE  (MCR_GATE),
    .FCR_KEEP  (FCR_KEEP),
    .GATE_BIT  (GATE_BIT),
    .RXCLR_BIT (1),
    .TXCLR_BIT (2)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .rid       (rid),
    .wr_en     (wr_en),
    .wdata     (wdata),
    .lcr_q     (lcr_q),
    .fcr_q     (fcr_q),
    .efr_q     (efr_q),
    .spr_q     (spr_q),
    .div_q     (div_q),
    .xon_q     (xon_q),
    .xoff_q    (xoff_q),
    .ier_vis   (ier_eff),
    .mcr_vis   (mcr_eff),
    .gate_open (gate_open),
    .rx_clr    (rx_fifo_clr),
    .tx_clr    (tx_fifo_clr)
  );

  uart_read_mux #(.ISR_GATE(ISR_GATE)) u_rmux (
    .rid       (rid),
    .rd_en     (rd_en),
    .rx_data   (rx_data),
    .isr_id    (isr_id),
    .lsr_stat  (lsr_stat),
    .msr_stat  (msr_stat),
    .ier_vis   (ier_eff),
    .mcr_vis   (mcr_eff),
    .lcr_q     (lcr_q),
    .fcr_q     (fcr_q),
    .efr_q     (efr_q),
    .spr_q     (spr_q),
    .div_q     (div_q),
    .xon_q     (xon_q),
    .xoff_q    (xoff_q),
    .gate_open (gate_open),
    .rdata     (rdata)
  );

  assign rx_pop    = rd_en && (rid == RID_HOLD);
  assign thr_push  = wr_en && (rid == RID_HOLD);
  assign thr_data  = wdata;

  assign word_len  = lcr_q[1:0];
  assign stop_two  = lcr_q[2];
  assign par_en    = lcr_q[3];
  assign par_even  = lcr_q[4];
  assign par_stick = lcr_q[5];
  assign brk       = lcr_q[6];
  assign divisor   = div_q;
  assign fifo_en   = fcr_q[0];
  assign dma_sel   = fcr_q[3];
  assign rx_trig   = fcr_q[7:6];
  assign xon_char  = xon_q;
  assign xoff_char = xoff_q;
  assign efr       = efr_q;

  a_r3_pop_general_only: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (rd_en && addr == 3'd0 && !lcr_q[7]));

  a_r3_push_general_only: assert property (@(posedge clk) disable iff (!rst_n)
    thr_push |-> (wr_en && addr == 3'd0 && !lcr_q[7]));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && lcr_q == ENH_KEY && addr[2:1] == 2'b00) |-> (rdata == 8'h00));

  a_r7_ier_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (!efr[GATE_BIT]) |-> (ier_eff[7:4] == 4'h0 && mcr_eff[6] == 1'b0));

endmodule

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = 8'h00, rx_data = 8'h00;
  logic [5:0]  isr_id = 6'h01;
  logic [7:0]  lsr_stat = 8'h60, msr_stat = 8'h00;
  logic [7:0]  rdata, thr_data, ier_eff, mcr_eff, efr;
  logic        rx_pop, thr_push, stop_two, par_en, par_even, par_stick, brk;
  logic        fifo_en, rx_fifo_clr, tx_fifo_clr, dma_sel;
  logic [1:0]  word_len, rx_trig;
  logic [15:0] divisor, xon_char, xoff_char;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_regbank u0 (.*);

  // ---------------- behavioural model ----------------
  int m_ier, m_fcr, m_lcr, m_mcr, m_efr, m_spr, m_dll, m_dlm;
  int m_xl, m_xh, m_fl, m_fh, m_rxc, m_txc;

  function automatic bit m_open(); return m_efr[4]; endfunction

  // which location an address reaches: "h" hold, etc.
  function automatic string where(int a);
    if (m_lcr == 'hBF) begin
      if (a == 2) return "efr";
      if (a == 3) return "lcr";
      if (a == 4) return "xl";
      if (a == 5) return "xh";
      if (a == 6) return "fl";
      if (a == 7) return "fh";
      return "none";
    end
    if (m_lcr[7] && a == 0) return "dll";
    if (m_lcr[7] && a == 1) return "dlm";
    case (a)
      0: return "hold"; 1: return "ier"; 2: return "isr"; 3: return "lcr";
      4: return "mcr"; 5: return "lsr"; 6: return "msr"; default: return "spr";
    endcase
  endfunction

  function automatic int exp_read();
    string w;
    int f;
    if (!rd_en) return 0;
    w = where(addr);
    f = m_fcr & 1;
    case (w)
      "hold": return rx_data;
      "ier":  return m_open() ? m_ier : (m_ier & 'h0F);
      "isr":  return (f << 7) | (f << 6) | (m_open() ? (isr_id & 'h30) : 0) | (isr_id & 'h0F);
      "lcr":  return m_lcr;
      "mcr":  return m_open() ? m_mcr : (m_mcr & 'hBF);
      "lsr":  return lsr_stat;
      "msr":  return msr_stat;
      "spr":  return m_spr;
      "dll":  return m_dll;
      "dlm":  return m_dlm;
      "efr":  return m_efr;
      "xl":   return m_xl;
      "xh":   return m_xh;
      "fl":   return m_fl;
      "fh":   return m_fh;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ier = 0; m_fcr = 0; m_lcr = 0; m_mcr = 0; m_efr = 0; m_spr = 'hFF;
      m_dll = 0; m_dlm = 0; m_xl = 0; m_xh = 0; m_fl = 0; m_fh = 0;
      m_rxc = 0; m_txc = 0;
    end else begin
      string w;
      int d;
      d = wdata;
      w = where(addr);
      m_rxc = 0; m_txc = 0;
      if (wr_en) begin
        case (w)
          "ier": m_ier = m_open() ? d : ((m_ier & 'hF0) | (d & 'h0F));
          "mcr": m_mcr = m_open() ? d : ((m_mcr & 'h40) | (d & 'hBF));
          "isr": begin m_fcr = d & 'hC9; m_rxc = (d >> 1) & 1; m_txc = (d >> 2) & 1; end
          "lcr": m_lcr = d;
          "spr": m_spr = d;
          "dll": m_dll = d;
          "dlm": m_dlm = d;
          "efr": m_efr = d;
          "xl":  m_xl = d;
          "xh":  m_xh = d;
          "fl":  m_fl = d;
          "fh":  m_fh = d;
          default: ;
        endcase
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic chk(string tag, string nm, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, nm, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    string w;
    w = where(addr);
    chk(tag, "rdata", rdata, exp_read());
    chk("R3", "rx_pop", rx_pop, (rd_en && w == "hold") ? 1 : 0);
    chk("R3", "thr_push", thr_push, (wr_en && w == "hold") ? 1 : 0);
    if (thr_push) chk("R3", "thr_data", thr_data, wdata);
    chk("R5", "lcr_fields", {brk, par_stick, par_even, par_en, stop_two, word_len}, m_lcr & 'h7F);
    chk("R8", "divisor", divisor, (m_dlm << 8) | m_dll);
    chk("R6", "fifo_fields", {rx_trig, dma_sel, fifo_en}, ((m_fcr >> 4) & 'hC) | ((m_fcr >> 2) & 2) | (m_fcr & 1));
    chk("R6", "rx_fifo_clr", rx_fifo_clr, m_rxc);
    chk("R6", "tx_fifo_clr", tx_fifo_clr, m_txc);
    chk("R7", "ier_eff", ier_eff, m_open() ? m_ier : (m_ier & 'h0F));
    chk("R7", "mcr_eff", mcr_eff, m_open() ? m_mcr : (m_mcr & 'hBF));
    chk("R2", "efr", efr, m_efr);
    chk("R2", "xon", xon_char, (m_xh << 8) | m_xl);
    chk("R2", "xoff", xoff_char, (m_fh << 8) | m_fl);
  endtask

  task automatic op(bit w, bit r, int a, int d, string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a[2:0]; wdata = d[7:0];
    #1 compare_all(tag);
  endtask

  task automatic wr(int a, int d, string tag); op(1, 0, a, d, tag); endtask
  task automatic rd(int a, string tag); op(0, 1, a, 0, tag); endtask
  task automatic idle(string tag); op(0, 0, 0, 0, tag); endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state visible across the general bank
    for (int a = 0; a < 8; a++) rd(a, "R1");
    idle("R1");

    // R5: character format fields
    wr(3, 'h1B, "R5"); rd(3, "R5");
    wr(3, 'h64, "R5"); rd(3, "R5");
    // R11: scratch
    wr(7, 'h5A, "R11"); rd(7, "R11");
    // R10: status pass-through
    lsr_stat = 8'h9F; msr_stat = 8'hA5; rd(5, "R10"); rd(6, "R10");
    lsr_stat = 8'h60; msr_stat = 8'h3C; rd(5, "R10"); rd(6, "R10");
    // R3: hold access strobes
    rx_data = 8'hC3; rd(0, "R3"); wr(0, 'h7E, "R3");
    // R8: divisor bank
    wr(3, 'h83, "R8"); wr(0, 'h34, "R8"); wr(1, 'h12, "R8");
    rd(0, "R8"); rd(1, "R8"); rd(3, "R5"); rd(7, "R11");
    // R6/R4: FIFO control and identification
    wr(2, 'hC7, "R6"); idle("R6"); rd(2, "R4");
    wr(2, 'h02, "R6"); wr(2, 'h04, "R6"); idle("R6");
    // R2/R9: enhanced bank
    wr(3, 'hBF, "R2"); wr(2, 'h10, "R2");
    wr(4, 'h11, "R2"); wr(5, 'h13, "R2"); wr(6, 'h91, "R2"); wr(7, 'h93, "R2");
    for (int a = 2; a < 8; a++) rd(a, "R2");
    rd(0, "R9"); rd(1, "R9"); wr(0, 'hEE, "R9"); wr(1, 'hDD, "R9");
    wr(3, 'h80, "R9"); rd(0, "R9"); rd(1, "R9");
    // R7: gate open, write high IER/MCR bits
    wr(3, 'h03, "R7"); wr(1, 'hFF, "R7"); wr(4, 'h5F, "R7");
    isr_id = 6'h3C; rd(1, "R7"); rd(4, "R7"); rd(2, "R4");
    // close gate, writes must not disturb stored high bits
    wr(3, 'hBF, "R7"); wr(2, 'h00, "R7"); wr(3, 'h03, "R7");
    rd(1, "R7"); rd(2, "R4"); wr(1, 'h05, "R7"); wr(4, 'h00, "R7");
    rd(1, "R7"); rd(4, "R7");
    wr(3, 'hBF, "R7"); wr(2, 'h10, "R7"); wr(3, 'h03, "R7");
    rd(1, "R7"); rd(4, "R7");

    // random traffic across banks
    for (int i = 0; i < 3000; i++) begin
      int a, d, k;
      k = $urandom_range(0, 9);
      a = $urandom_range(0, 7);
      d = $urandom_range(0, 255);
      rx_data = 8'($urandom); msr_stat = 8'($urandom);
      lsr_stat = 8'($urandom); isr_id = 6'($urandom);
      if (k == 0)      wr(3, 'hBF, "R2");
      else if (k == 1) wr(3, 'h80 | (d & 'h7F), "R2");
      else if (k == 2) wr(3, d & 'h7F, "R2");
      else if (k < 6)  wr(a, d, "R2");
      else             rd(a, "R2");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule